// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

The block gathers a parameterised set of interrupt sources and presents one request with a vector address to a CPU. Every source is fixed at build time as either event type or level type. An event source latches a flag that persists until it is serviced or cleared by software. A level source is not remembered: it requests only while its input is high. Each source has its own enable, and one global enable gates them all. The pending source with the lowest index wins.

The request and the acknowledge form a handshake. `irq_o` acts as valid and `ack_i` acts as ready. An acknowledge counts only in a cycle where `irq_o` is high. The vector in that cycle is the one taken. While no acknowledge arrives, `irq_o` stays up for as long as a qualified source is pending. A higher-priority arrival can change `vec_o` before the acknowledge. Taking a vector clears the global enable and the serviced flag.

A return strobe sets the global enable again. It also blocks the request until the CPU signals that one more instruction has retired. A control bit moves the vector table from address zero to a boot base given as a parameter. Software configures the block through a small write port:

- address 0 loads the enable mask;
- address 1 clears flags, write-one-to-clear;
- address 2 is control: bit 0 is the global enable and bit 1 is boot relocation;
- address 3 is ignored.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all flags, enables, the global enable and relocation are zero, and `irq_o` is 0.
- R2: An event-type source sets its flag on any cycle its input is 1. The flag stays set while the source or the global enable is off. It raises `irq_o` once both enables are 1.
- R3: A level-type source (bit set in `LEVEL_MASK`; source 4 by default) requests only in cycles where its input is 1 and holds no memory. A pulse seen while it is disabled produces no later request.
- R4: `irq_o` is 1 only when some pending source has its enable bit at 1 and the global enable (control bit 0) is 1.
- R5: Among pending sources the lowest index wins. `vec_o` = base + (index+1)·`VEC_STRIDE`, because slot 0 of the table is reset. With the defaults, source k gives 2(k+1).
- R6: An acknowledge while `irq_o` is 1 clears the global enable and the winner's flag, so `irq_o` is 0 in the next cycle. An acknowledge while `irq_o` is 0 has no effect.
- R7: Writing a 1 to a bit at address 1 clears that flag. An event arriving in the same cycle as the clear leaves the flag set.
- R8: A return strobe sets the global enable, and `irq_o` is 0 from the next cycle until a clock edge with `instr_ret_i` at 1 has passed.
- R9: A control write with bit 0 at 0 forces `irq_o` to 0 in that same cycle, and an acknowledge in that cycle is ignored.
- R10: Control bit 1 set to 1 makes the base `BOOT_BASE`; when it is 0 the base is 0.
- R11: Software setting the global enable inside a handler lets a newly pending source request at once (nesting).
- R12: Several flags pending together are served one per acknowledge in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N | Source inputs (events or levels) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | N | Write data |
| instr_ret_i | input | 1 | An instruction retired this cycle |
| ack_i | input | 1 | CPU takes the current vector (ready) |
| reti_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Interrupt request (valid) |
| vec_o | output | ADDR_W | Vector address of the winning source |

## Verification
Some rules are checked by assertions on every cycle:

- the request falls the cycle after an accepted acknowledge and after a return strobe;
- a disabling control write kills the request combinationally;
- no flag is lost unless it was cleared;
- a request always has a qualified pending source behind it;
- a request's vector lies on a table slot.

Only the bench's scenarios can show the rest:

- the exact vector values and the order in which stacked flags are served;
- that a level pulse seen while disabled leaves nothing behind;
- the outcome when an event and a clear collide;
- that the post-return block releases on the retire strobe;
- that relocation and nesting work.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_FLAG_CLR = 2'd1,
    REG_CTRL     = 2'd2,
    REG_SPARE    = 2'd3
  } reg_sel_e;

  localparam int CTRL_GIE_BIT   = 0;
  localparam int CTRL_RELOC_BIT = 1;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N = 8,
  parameter logic [N-1:0] LEVEL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_data_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_n;

  // Event wins over a clear in the same cycle; level sources keep no flag.
  assign flag_n = ((flag_q & ~clr_i) | src_i) & ~LEVEL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= flag_n;
      if (en_wr_i) en_q <= en_data_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign pend_o[i] = en_q[i] & src_i[i];
    end else begin : g_event
      assign pend_o[i] = en_q[i] & flag_q[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  // Lowest set bit isolates the winner.
  assign grant_o = pend_i & ~(pend_i - N'(1));
  assign any_o   = |pend_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr_i,
  input  logic [1:0] ctrl_data_i,
  input  logic       ack_take_i,
  input  logic       reti_i,
  input  logic       instr_ret_i,
  output logic       gie_o,
  output logic       hold_o,
  output logic       reloc_o
);
  logic gie_q, hold_q, reloc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      hold_q  <= 1'b0;
      reloc_q <= 1'b0;
    end else begin
      if (ack_take_i)     gie_q <= 1'b0;
      else if (reti_i)    gie_q <= 1'b1;
      else if (ctrl_wr_i) gie_q <= ctrl_data_i[irq_pkg::CTRL_GIE_BIT];

      if (ctrl_wr_i) reloc_q <= ctrl_data_i[irq_pkg::CTRL_RELOC_BIT];

      if (reti_i)           hold_q <= 1'b1;
      else if (instr_ret_i) hold_q <= 1'b0;
    end
  end

  assign gie_o   = gie_q;
  assign hold_o  = hold_q;
  assign reloc_o = reloc_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 8,
  parameter int ADDR_W = 16,
  parameter int VEC_STRIDE = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800,
  parameter logic [N-1:0] LEVEL_MASK = 8'b0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [N-1:0]      wr_data_i,
  input  logic              instr_ret_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_o
);
  import irq_pkg::*;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             en_wr, w1c_wr, ctrl_wr, kill_now, ack_take;
  logic             any_pend, gie, hold, reloc;
  logic [N-1:0]     pend_w, flag_w, grant_w, clr_vec;
  logic [IDX_W-1:0] idx_w;
  logic [ADDR_W-1:0] base_w, slot_w;

  assign en_wr   = wr_en_i && (wr_addr_i == REG_ENABLE);
  assign w1c_wr  = wr_en_i && (wr_addr_i == REG_FLAG_CLR);
  assign ctrl_wr = wr_en_i && (wr_addr_i == REG_CTRL);

  // A disabling control write blocks the request in its own cycle.
  assign kill_now = ctrl_wr && !wr_data_i[CTRL_GIE_BIT];
  assign irq_o    = any_pend && gie && !hold && !kill_now;
  assign ack_take = ack_i && irq_o;

  assign clr_vec = (w1c_wr ? wr_data_i : '0) | (ack_take ? grant_w : '0);

  irq_src_bank #(.N(N), .LEVEL_MASK(LEVEL_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .en_wr_i(en_wr), .en_data_i(wr_data_i), .clr_i(clr_vec),
    .flag_o(flag_w), .pend_o(pend_w)
  );

  irq_prio_sel #(.N(N)) u_sel (
    .pend_i(pend_w), .any_o(any_pend), .idx_o(idx_w), .grant_o(grant_w)
  );

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_data_i(wr_data_i[1:0]),
    .ack_take_i(ack_take), .reti_i(reti_i), .instr_ret_i(instr_ret_i),
    .gie_o(gie), .hold_o(hold), .reloc_o(reloc)
  );

  assign base_w = reloc ? BOOT_BASE : '0;
  assign slot_w = ADDR_W'(idx_w) + ADDR_W'(1);
  assign vec_o  = base_w + slot_w * ADDR_W'(VEC_STRIDE);
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N = 8,
  parameter int ADDR_W = 16,
  parameter int VEC_STRIDE = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              ack_i,
  input logic              reti_i,
  input logic              ctrl_wr,
  input logic              gie_bit,
  input logic [ADDR_W-1:0] vec_o,
  input logic              reloc,
  input logic [N-1:0]      flag_w,
  input logic [N-1:0]      clr_vec,
  input logic [N-1:0]      pend_w
);
  logic [ADDR_W-1:0] base_c;
  assign base_c = reloc ? BOOT_BASE : '0;

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !irq_o); // R6
  AST_RETI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> !irq_o); // R8
  AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !gie_bit) |-> !irq_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_w) & ~$past(clr_vec)) & ~flag_w) == '0)); // R2
  AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_w != '0)); // R4
  AST_VEC_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((vec_o >= base_c + ADDR_W'(VEC_STRIDE)) &&
               (vec_o <= base_c + ADDR_W'(N * VEC_STRIDE)) &&
               (((vec_o - base_c) % ADDR_W'(VEC_STRIDE)) == '0))); // R5
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .N(N), .ADDR_W(ADDR_W), .VEC_STRIDE(VEC_STRIDE), .BOOT_BASE(BOOT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ack_i(ack_i), .reti_i(reti_i),
  .ctrl_wr(ctrl_wr), .gie_bit(wr_data_i[0]), .vec_o(vec_o), .reloc(reloc),
  .flag_w(flag_w), .clr_vec(clr_vec), .pend_w(pend_w)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  localparam int N = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic instr_ret = 1'b0, ack = 1'b0, reti = 1'b0;
  logic irq;
  logic [AW-1:0] vec;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .instr_ret_i(instr_ret), .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every accepted acknowledge is compared with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && ack && irq) begin
      if (exp_q.size() == 0) check("R5 unexpected ack", vec, '1);
      else check("R5/R12 scoreboard vector", vec, exp_q.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic pulse_src(logic [N-1:0] m);
    src = m; tick(); src = '0;
  endtask

  task automatic do_ack(logic [AW-1:0] e);
    exp_q.push_back(e); ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  task automatic do_retire();
    instr_ret = 1'b1; tick(); instr_ret = 1'b0;
  endtask

  task automatic see(string req, logic exp_irq, logic [AW-1:0] exp_vec, bit chk_vec);
    @(negedge clk);
    check(req, AW'(irq), AW'(exp_irq));
    if (chk_vec) check(req, vec, exp_vec);
    tick();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    see("R1 reset idle", 1'b0, '0, 1'b0);

    pulse_src(8'h04);
    see("R2 flag while disabled", 1'b0, '0, 1'b0);
    wr(2'd0, 8'hFF);
    see("R4 global enable off", 1'b0, '0, 1'b0);
    wr(2'd2, 8'h01);
    see("R2 latched flag served", 1'b1, 16'd6, 1'b1);
    do_ack(16'd6);
    see("R6 request drops after ack", 1'b0, '0, 1'b0);
    wr(2'd2, 8'h01);
    see("R6 flag cleared by ack", 1'b0, '0, 1'b0);

    // Level source 4.
    src = 8'h10;
    see("R3 level present", 1'b1, 16'd10, 1'b1);
    src = '0;
    see("R3 level gone", 1'b0, '0, 1'b0);
    wr(2'd0, 8'hEF);
    src = 8'h10;
    see("R4 level disabled", 1'b0, '0, 1'b0);
    src = '0;
    wr(2'd0, 8'hFF);
    see("R3 no memory of level", 1'b0, '0, 1'b0);

    // Write-one-to-clear.
    wr(2'd2, 8'h00);
    pulse_src(8'h28);
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h01);
    see("R7 cleared flag skipped", 1'b1, 16'd12, 1'b1);
    src = 8'h20; wr(2'd1, 8'h20); src = '0;
    see("R7 event beats clear", 1'b1, 16'd12, 1'b1);
    wr(2'd1, 8'h20);
    see("R7 clear", 1'b0, '0, 1'b0);

    // Stacked flags, return gap.
    wr(2'd2, 8'h00);
    pulse_src(8'h4A);
    wr(2'd2, 8'h01);
    see("R12 lowest index first", 1'b1, 16'd4, 1'b1);
    do_ack(16'd4);
    do_reti();
    see("R8 gap after return", 1'b0, '0, 1'b0);
    do_retire();
    see("R8 released after retire", 1'b1, 16'd8, 1'b1);
    do_ack(16'd8);
    do_reti();
    do_retire();
    see("R12 third in order", 1'b1, 16'd14, 1'b1);
    do_ack(16'd14);

    // Immediate disable.
    pulse_src(8'h01);
    wr(2'd2, 8'h01);
    see("R5 source 0 vector", 1'b1, 16'd2, 1'b1);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00; ack = 1'b1;
    @(negedge clk);
    check("R9 disable same cycle", AW'(irq), 16'd0);
    tick(); wr_en = 1'b0; ack = 1'b0;
    wr(2'd2, 8'h01);
    see("R9 ack ignored, flag kept", 1'b1, 16'd2, 1'b1);
    do_ack(16'd2);

    // Relocation.
    pulse_src(8'h04);
    wr(2'd2, 8'h03);
    see("R10 boot base", 1'b1, 16'h3806, 1'b1);
    do_ack(16'h3806);

    // Nesting inside the handler.
    pulse_src(8'h02);
    see("R11 in handler, off", 1'b0, '0, 1'b0);
    wr(2'd2, 8'h03);
    see("R11 nested request", 1'b1, 16'h3804, 1'b1);
    do_ack(16'h3804);

    // Per-source enable.
    wr(2'd0, 8'hFB);
    pulse_src(8'h04);
    wr(2'd2, 8'h03);
    see("R4 source disabled", 1'b0, '0, 1'b0);
    wr(2'd0, 8'hFF);
    see("R2 kept while disabled", 1'b1, 16'h3806, 1'b1);
    do_ack(16'h3806);

    tick();
    check("R6 scoreboard drained", AW'(exp_q.size()), 16'd0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule